// File: doc/BRIEF.md
# Register Rename Table with Free List

This block renames one instruction per cycle. It maps the architectural register file onto a larger pool of physical registers, using an alias table and a free list of unused physical indices. A request carries two source indices and one destination index. Both sources return the physical register they are currently mapped to.

A request that writes a register takes the next physical register from the free list and points the alias table at it. The physical register that held the destination before is reported on its own output, so the reorder buffer can keep it. When that instruction commits, the reorder buffer hands the old register back through the release port, and it goes onto the tail of the free list. Architectural register 0 is never renamed: it always reads physical register 0.

The lookups and the allocation are combinational within the request cycle. The alias table, the free-list pointers and the free count all update on the following rising clock edge.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and the free list holds physical registers 32 to 127 in ascending order.
- R2: In the request cycle, each source output shows the mapping of its source index as it stood before that cycle's edge. A request after a rename sees the new physical register.
- R3: A request that is valid, has `req_has_dst` high and a non-zero destination allocates the free-list head on `dst_new_phys` in the same cycle. From the next edge, the destination maps to that register and the free count drops by one.
- R4: For a request with a non-zero destination, `dst_old_phys` shows the destination's mapping before the request. `dst_new_phys` differs from it whenever an allocation happens.
- R5: A destination index of 0, or `req_has_dst` low, allocates nothing, never stalls, and drives 0 on `dst_new_phys` and `dst_old_phys`. Source index 0 always returns physical register 0.
- R6: When a source index equals the destination index in the same request, the source output shows the mapping from before the rename.
- R7: When the free list is empty and a request needs a destination, `stall` is high and `dst_new_phys` is 0. The alias table and the allocate pointer do not change. This holds even if a release arrives in the same cycle.
- R8: A register given on the release port with `rel_valid` high is written at the tail of the free list. It is allocated only after every register that was already in the list.
- R9: A release and an allocation in the same cycle both take effect, so the free count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Rename request present |
| req_has_dst | input | 1 | Request writes a destination register |
| req_src_a | input | 5 | First source architectural index |
| req_src_b | input | 5 | Second source architectural index |
| req_dst | input | 5 | Destination architectural index |
| src_a_phys | output | 7 | Physical mapping of the first source |
| src_b_phys | output | 7 | Physical mapping of the second source |
| dst_new_phys | output | 7 | Newly allocated physical destination (0 if none) |
| dst_old_phys | output | 7 | Previous mapping of the destination (0 if none) |
| stall | output | 1 | Request needs a register but the free list is empty |
| rel_valid | input | 1 | Committed instruction releases a register |
| rel_phys | input | 7 | Physical register to return to the free list |

## Verification
All rename outputs are due in the same cycle as the request. The bench drives the inputs just after a rising edge and compares the outputs at the following falling edge, before any state moves.

Table and free-list effects become visible one edge later. The bench therefore checks them through the source outputs and `dst_new_phys` of later requests: allocation order, reuse of released registers, and the unchanged table after a stall. A reference model updates its table and queue in the bench at the same edge the design does.

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 128,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_has_dst,
  input  logic [AW-1:0] req_src_a,
  input  logic [AW-1:0] req_src_b,
  input  logic [AW-1:0] req_dst,
  output logic [PW-1:0] src_a_phys,
  output logic [PW-1:0] src_b_phys,
  output logic [PW-1:0] dst_new_phys,
  output logic [PW-1:0] dst_old_phys,
  output logic          stall,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_phys
);
  localparam int DEPTH = PHYS_REGS - ARCH_REGS;
  localparam int QW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [PW-1:0] amap [ARCH_REGS];
  logic [PW-1:0] flq  [DEPTH];
  logic [QW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          needs, alloc;

  function automatic logic [QW-1:0] wrap_inc(input logic [QW-1:0] p);
    return (p == QW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign needs        = req_valid && req_has_dst && (req_dst != '0);
  assign stall        = needs && (cnt == '0);
  assign alloc        = needs && !stall;
  assign src_a_phys   = amap[req_src_a];
  assign src_b_phys   = amap[req_src_b];
  assign dst_old_phys = needs ? amap[req_dst] : '0;
  assign dst_new_phys = alloc ? flq[rd_ptr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) amap[i] <= PW'(i);
    end else if (alloc) begin
      amap[req_dst] <= flq[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) flq[i] <= PW'(ARCH_REGS + i);
    end else if (rel_valid) begin
      flq[wr_ptr] <= rel_phys;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= CW'(DEPTH);
    end else begin
      if (alloc)     rd_ptr <= wrap_inc(rd_ptr);
      if (rel_valid) wr_ptr <= wrap_inc(wr_ptr);
      cnt <= cnt + CW'(rel_valid) - CW'(alloc);
    end
  end

  // R3
  alloc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !rel_valid) |=> (cnt == $past(cnt) - 1'b1));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rel_valid) |=> ($stable(cnt) && $stable(rd_ptr)));

  // R9
  both_ports_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && rel_valid) |=> $stable(cnt));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (cnt < CW'(DEPTH)));

  // R4
  fresh_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (dst_new_phys != dst_old_phys));

  // R5
  zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_dst == '0) |-> (!stall && dst_new_phys == '0));
endmodule

// File: tb/test_reg_rename.sv
`timescale 1ns/100ps
module test_reg_rename;
  localparam int NA = 32, NP = 128, ND = NP - NA;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_has_dst = 0, rel_valid = 0;
  logic [4:0] req_src_a = 0, req_src_b = 0, req_dst = 0;
  logic [6:0] rel_phys = 0;
  logic [6:0] src_a_phys, src_b_phys, dst_new_phys, dst_old_phys;
  logic stall;

  int nchk = 0, nfail = 0;
  int mmap [NA];
  int q [ND];
  int qh, qt, qc;
  int olds [ND];
  int no;

  always #2 clk = ~clk;

  reg_rename i_reg_rename (.*);

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NA; i++) mmap[i] = i;
    for (int i = 0; i < ND; i++) q[i] = NA + i;
    qh = 0; qt = 0; qc = ND; no = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; req_valid = 0; rel_valid = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    model_reset();
  endtask

  task automatic cyc(input bit v, input bit hd, input int d, input int sa, input int sb,
                     input bit rv, input int rp, input string tag);
    bit need, st, en;
    int en_new, en_old;
    req_valid = v; req_has_dst = hd; req_dst = 5'(d);
    req_src_a = 5'(sa); req_src_b = 5'(sb);
    rel_valid = rv; rel_phys = 7'(rp);
    @(negedge clk);
    need = v && hd && d != 0;
    st = need && qc == 0;
    en = need && !st;
    en_new = en ? q[qh] : 0;
    en_old = need ? mmap[d] : 0;
    chk({tag, " src_a"}, int'(src_a_phys), mmap[sa]);
    chk({tag, " src_b"}, int'(src_b_phys), mmap[sb]);
    chk({tag, " stall"}, int'(stall), int'(st));
    chk({tag, " new"}, int'(dst_new_phys), en_new);
    chk({tag, " old"}, int'(dst_old_phys), en_old);
    if (en) begin
      mmap[d] = q[qh]; qh = (qh + 1) % ND; qc--;
      olds[no % ND] = en_old; no++;
    end
    if (rv) begin
      q[qt] = rp; qt = (qt + 1) % ND; qc++;
    end
    @(posedge clk); #1;
    req_valid = 0; rel_valid = 0;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    join_none

    do_reset();
    // R1 reset map, swept over every index through both sources
    for (int i = 0; i < NA; i++) cyc(0, 0, 0, i, NA - 1 - i, 0, 0, "R1");
    // R5 zero destination and no-destination requests
    cyc(1, 1, 0, 0, 3, 0, 0, "R5 x0");
    cyc(1, 0, 5, 5, 0, 0, 0, "R5 nodst");
    // R2 R3 R4 R6 drain the whole free list, sources read dst and previous dst
    for (int k = 0; k < ND; k++) begin
      int d = 1 + (k % (NA - 1));
      int p = (k == 0) ? 0 : 1 + ((k - 1) % (NA - 1));
      cyc(1, 1, d, d, p, 0, 0, "R2/R3/R4/R6");
    end
    // R7 empty list stalls, even with a release in the same cycle
    cyc(1, 1, 7, 7, 0, 0, 0, "R7 empty");
    cyc(1, 1, 7, 7, 0, 1, olds[0], "R7 stall+release");
    // R8 released register comes out next
    cyc(1, 1, 7, 7, 9, 0, 0, "R8 reuse");
    cyc(1, 1, 8, 7, 8, 1, olds[1], "R8 refill");
    // R9 release and allocate together keep the count
    cyc(1, 1, 9, 9, 8, 1, olds[2], "R9 both");
    cyc(1, 1, 10, 9, 10, 0, 0, "R9 after");
    cyc(1, 1, 11, 10, 11, 0, 0, "R7 empty again");
    // R8 ordering over several releases
    for (int k = 3; k < 8; k++) cyc(0, 0, 0, 0, 0, 1, olds[k], "R8 fill");
    for (int k = 0; k < 6; k++) cyc(1, 1, 12 + k, 12 + k, 1, 0, 0, "R8 order");
    // R1 second reset restores identity and allocation start
    do_reset();
    for (int i = 0; i < NA; i++) cyc(0, 0, 0, i, i, 0, 0, "R1 again");
    cyc(1, 1, 31, 31, 0, 0, 0, "R3 first");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule